// File: doc/BRIEF.md
# Playback Count Interrupt Engine

This block watches the byte stream a DMA engine delivers to a playback path and raises an interrupt each time a programmed number of samples has gone by. Software programs a 16-bit sample count, a format byte and two enables. The block turns the format byte into a byte-per-sample scaling shift, counts accepted bytes against the scaled count, and sets a pending-interrupt flag when the count is reached. Software clears the flag with a one-cycle clear strobe.

The format byte also selects the crystal rate table and rate index. The block checks both fields, and a reserved or unsupported setting stops playback. The DMA side offers bytes on `byteValid` and sees `byteReady` as backpressure. Bytes are refused while playback is stopped. They are also refused for one cycle after a terminal count, and whenever the counter already sits at or past the scaled count.

Top module: `pbk_count_irq`

## Requirements
- R1: After reset `irqPend`, `byteReady` and `running` are 0.
- R2: The format code is `fmtReg[7:5]`, with bit 7 forced to 0 unless `modeExt` is 1. Codes 4, 5 and 7 set `fmtErr`. Codes 0, 1, 2, 3 and 6 leave it clear.
- R3: `rateSel` equals `{fmtReg[0], fmtReg[3:1]}`. `rateOk` is 0 exactly when `fmtReg[0]` is 0 and `fmtReg[3:1]` is 4 or 5.
- R4: `shiftOut` follows the code and the channel count. With stereo taken from `fmtReg[4]`, codes 0, 1 and 3 give the stereo bit, and codes 2 and 6 give 2 for stereo and 1 for mono.
- R5: `running` and `byteReady` can be 1 only from the cycle after `playEn` is 1 with a valid format and rate. A start from the stopped state resets the byte counter to 0.
- R6: With `cntIntEn` at 1, `irqPend` goes to 1 the cycle after the accepted byte that brings the count to `baseCnt << shiftOut`. The counter then restarts from 0.
- R7: `byteReady` is 0 for exactly the one cycle in which `irqPend` rises, then returns to 1.
- R8: With `cntIntEn` at 0, accepted bytes are not counted and `irqPend` never rises.
- R9: With `cntIntEn` at 1 and a scaled count of 0, `byteReady` stays 0.
- R10: `intClr` clears `irqPend` on the next cycle. A terminal count in the same cycle wins, and the flag stays 1.
- R11: An invalid format or rate makes `running` and `byteReady` 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtReg | input | 8 | Playback format byte (code, stereo, rate index, crystal select) |
| modeExt | input | 1 | Extended mode: enables the third format code bit |
| playEn | input | 1 | Playback enable |
| cntIntEn | input | 1 | Enable counting toward the interrupt |
| baseCnt | input | CNT_W | Programmed sample count |
| byteValid | input | 1 | A byte is offered by the DMA side |
| intClr | input | 1 | Clear the pending interrupt |
| byteReady | output | 1 | Byte accepted when high together with byteValid |
| irqPend | output | 1 | Pending playback interrupt and interrupt line |
| fmtErr | output | 1 | Reserved or unsupported format code |
| rateOk | output | 1 | Rate selection is valid |
| rateSel | output | 4 | Crystal select and rate index for the clock logic |
| shiftOut | output | 2 | Count scaling shift |
| running | output | 1 | Playback active |

## Verification
The bench builds the block with `CNT_W = 4`, so every base count from 0 to 15 can be swept, and the scaled terminal counts stay at or below 60 bytes. That small size puts a full cross of all eight format codes, both `modeExt` settings, both channel counts and every base count within reach, along with the zero-count stall. All sixteen rate nibbles are checked as well. Directed sequences then cover a restart in the middle of a block, counting while disabled, a clear that collides with a terminal count, and a format error that appears while playback runs.

// File: rtl/pbk_cnt_pkg.sv
package pbk_cnt_pkg;

  // Command strobes from the control to the counting datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
  } cntCmd_t;

  typedef enum logic [2:0] {
    FMT_U8    = 3'd0,
    FMT_ULAW  = 3'd1,
    FMT_S16LE = 3'd2,
    FMT_ALAW  = 3'd3,
    FMT_RSV4  = 3'd4,
    FMT_ADPCM = 3'd5,
    FMT_S16BE = 3'd6,
    FMT_RSV7  = 3'd7
  } fmtCode_t;

endpackage

// File: rtl/pbk_fmt_decode.sv
module pbk_fmt_decode
  import pbk_cnt_pkg::*;
#(
  parameter int RATE_IDX_W = 3
) (
  input  logic [7:0]            fmtReg,
  input  logic                  modeExt,
  output logic                  fmtErr,
  output logic                  rateOk,
  output logic [RATE_IDX_W:0]   rateSel,
  output logic [1:0]            shiftOut
);
  localparam int IDX_LO = 1;
  localparam int IDX_HI = IDX_LO + RATE_IDX_W - 1;

  fmtCode_t code;
  logic     stereo;
  logic [RATE_IDX_W-1:0] rateIdx;

  assign code    = fmtCode_t'(fmtReg[7:5] & {modeExt, 2'b11});
  assign stereo  = fmtReg[4];
  assign rateIdx = fmtReg[IDX_HI:IDX_LO];
  assign rateSel = {fmtReg[0], rateIdx};

  // The first crystal table has two holes
  assign rateOk = fmtReg[0] ||
                  !((rateIdx == RATE_IDX_W'(4)) || (rateIdx == RATE_IDX_W'(5)));

  always_comb begin
    fmtErr   = 1'b0;
    shiftOut = 2'd0;
    unique case (code)
      FMT_U8, FMT_ULAW, FMT_ALAW: shiftOut = {1'b0, stereo};
      FMT_S16LE, FMT_S16BE:       shiftOut = stereo ? 2'd2 : 2'd1;
      default:                    fmtErr   = 1'b1;
    endcase
  end

endmodule

// File: rtl/pbk_cnt_path.sv
module pbk_cnt_path
  import pbk_cnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] baseCnt,
  input  logic [1:0]       shift,
  input  cntCmd_t          cmd,
  output logic             nextHit,
  output logic             atLimit
);
  localparam int TERM_W = CNT_W + 2;

  logic [TERM_W-1:0] term;
  logic [TERM_W-1:0] cnt;
  logic [TERM_W-1:0] cntInc;

  assign term    = {2'b00, baseCnt} << shift;
  assign cntInc  = cnt + TERM_W'(1);
  assign nextHit = (cntInc == term);
  assign atLimit = (cnt >= term);

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (cmd.clrCnt)  cnt <= '0;
    else if (cmd.incCnt)  cnt <= cntInc;
  end

  // R9: the control never counts a byte at or past the terminal count
  p_inc_below_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.incCnt |-> (cnt < term));

endmodule

// File: rtl/pbk_cnt_ctrl.sv
module pbk_cnt_ctrl
  import pbk_cnt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    playEn,
  input  logic    cfgOk,
  input  logic    cntIntEn,
  input  logic    byteValid,
  input  logic    intClr,
  input  logic    nextHit,
  input  logic    atLimit,
  output logic    byteReady,
  output logic    irqPend,
  output logic    running,
  output cntCmd_t cmd
);
  logic runQ, hitQ, pendQ;
  logic startNow, accept, termHit;

  assign startNow  = playEn && cfgOk && !runQ;
  assign byteReady = runQ && !hitQ && !(cntIntEn && atLimit);
  assign accept    = byteValid && byteReady;
  assign termHit   = accept && cntIntEn && nextHit;

  assign cmd.incCnt = accept && cntIntEn;
  assign cmd.clrCnt = startNow || termHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      hitQ  <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      runQ <= playEn && cfgOk;
      hitQ <= termHit;
      if (termHit)     pendQ <= 1'b1;
      else if (intClr) pendQ <= 1'b0;
    end
  end

  assign irqPend = pendQ;
  assign running = runQ;

  // R7: one bubble on the byte side when the interrupt rises
  p_bubble_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPend) |-> !byteReady);

  // R11: a bad format or rate stops playback one cycle later
  p_err_stop_r11: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOk |=> !byteReady);

  // R10: a clear without a competing terminal count drops the flag
  p_clr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intClr && !termHit) |=> !irqPend);

  // R6: a terminal count always leaves the flag set
  p_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    termHit |=> irqPend);

endmodule

// File: rtl/pbk_count_irq.sv
module pbk_count_irq
  import pbk_cnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       fmtReg,
  input  logic             modeExt,
  input  logic             playEn,
  input  logic             cntIntEn,
  input  logic [CNT_W-1:0] baseCnt,
  input  logic             byteValid,
  input  logic             intClr,
  output logic             byteReady,
  output logic             irqPend,
  output logic             fmtErr,
  output logic             rateOk,
  output logic [3:0]       rateSel,
  output logic [1:0]       shiftOut,
  output logic             running
);
  cntCmd_t cmd;
  logic    nextHit, atLimit, cfgOk;

  pbk_fmt_decode #(.RATE_IDX_W(3)) uDec (
    .fmtReg   (fmtReg),
    .modeExt  (modeExt),
    .fmtErr   (fmtErr),
    .rateOk   (rateOk),
    .rateSel  (rateSel),
    .shiftOut (shiftOut)
  );

  assign cfgOk = !fmtErr && rateOk;

  pbk_cnt_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .playEn    (playEn),
    .cfgOk     (cfgOk),
    .cntIntEn  (cntIntEn),
    .byteValid (byteValid),
    .intClr    (intClr),
    .nextHit   (nextHit),
    .atLimit   (atLimit),
    .byteReady (byteReady),
    .irqPend   (irqPend),
    .running   (running),
    .cmd       (cmd)
  );

  pbk_cnt_path #(.CNT_W(CNT_W)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .baseCnt (baseCnt),
    .shift   (shiftOut),
    .cmd     (cmd),
    .nextHit (nextHit),
    .atLimit (atLimit)
  );

endmodule

// File: tb/tb_pbk_count_irq.sv
module tb_pbk_count_irq;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] fmtReg = 8'h00;
  logic modeExt = 1'b0, playEn = 1'b0, cntIntEn = 1'b0;
  logic [CNT_W-1:0] baseCnt = '0;
  logic byteValid = 1'b0, intClr = 1'b0;
  logic byteReady, irqPend, fmtErr, rateOk, running;
  logic [3:0] rateSel;
  logic [1:0] shiftOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pbk_count_irq #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .fmtReg(fmtReg), .modeExt(modeExt),
    .playEn(playEn), .cntIntEn(cntIntEn), .baseCnt(baseCnt),
    .byteValid(byteValid), .intClr(intClr), .byteReady(byteReady),
    .irqPend(irqPend), .fmtErr(fmtErr), .rateOk(rateOk),
    .rateSel(rateSel), .shiftOut(shiftOut), .running(running)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Deliver k accepted bytes; returns just after the negedge following the last accept
  task automatic pushBytes(input int k);
    int n = 0;
    int guard = 0;
    bit rdy;
    if (k == 0) return;
    byteValid = 1'b1;
    while (n < k && guard < 1000) begin
      #1 rdy = byteReady;
      @(negedge clk);
      guard++;
      if (rdy) n++;
      if (n == k) byteValid = 1'b0;
    end
    byteValid = 1'b0;
    #1;
  endtask

  // Stop, program, restart; returns 1 ns after the first running negedge
  task automatic startPlay(input logic [7:0] f, input logic mx, input int base, input logic ien);
    @(negedge clk);
    playEn = 1'b0; byteValid = 1'b0;
    @(negedge clk);
    fmtReg = f; modeExt = mx; baseCnt = CNT_W'(base); cntIntEn = ien;
    playEn = 1'b1; intClr = 1'b1;
    @(negedge clk);
    intClr = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(irqPend == 1'b0, "R1 irqPend", irqPend, 0);
    chk(byteReady == 1'b0, "R1 byteReady", byteReady, 0);
    chk(running == 1'b0, "R1 running", running, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R3 rate nibble sweep
    for (int f = 0; f < 16; f++) begin
      fmtReg = 8'(f);
      #1;
      chk(rateSel == {fmtReg[0], fmtReg[3:1]}, "R3 rateSel", rateSel, {f[0], f[3:1]});
      chk(rateOk == !(f[0] == 1'b0 && (f[3:1] == 3'd4 || f[3:1] == 3'd5)),
          "R3 rateOk", rateOk, !(f[0] == 1'b0 && (f[3:1] == 3'd4 || f[3:1] == 3'd5)));
      @(negedge clk);
    end

    // Sweep: codes x mode x stereo x base counts
    for (int code = 0; code < 8; code++)
      for (int mx = 0; mx < 2; mx++)
        for (int st = 0; st < 2; st++)
          for (int base = 0; base < 16; base++) begin
            int masked, expShift, term;
            bit bad;
            masked = (mx != 0) ? code : (code & 3);
            bad = (masked == 4) || (masked == 5) || (masked == 7);
            startPlay({3'(code), 1'(st), 3'b000, 1'b0}, 1'(mx), base, 1'b1);
            chk(fmtErr == bad, "R2 fmtErr", fmtErr, bad);
            if (bad) begin
              chk(byteReady == 1'b0 && running == 1'b0, "R11 stopped", byteReady, 0);
              continue;
            end
            expShift = (masked == 2 || masked == 6) ? ((st != 0) ? 2 : 1) : st;
            chk(int'(shiftOut) == expShift, "R4 shiftOut", shiftOut, expShift);
            term = base << expShift;
            if (term == 0) begin
              chk(byteReady == 1'b0, "R9 zero count stall", byteReady, 0);
              continue;
            end
            chk(byteReady == 1'b1, "R5 ready after start", byteReady, 1);
            pushBytes(term - 1);
            chk(irqPend == 1'b0, "R6 no early irq", irqPend, 0);
            pushBytes(1);
            chk(irqPend == 1'b1, "R6 irq at terminal", irqPend, 1);
            chk(byteReady == 1'b0, "R7 bubble", byteReady, 0);
            @(negedge clk); #1;
            chk(byteReady == 1'b1, "R7 bubble ends", byteReady, 1);
          end

    // R8 counting disabled
    startPlay(8'h00, 1'b0, 3, 1'b0);
    pushBytes(10);
    chk(irqPend == 1'b0, "R8 no irq when disabled", irqPend, 0);
    chk(byteReady == 1'b1, "R8 still accepting", byteReady, 1);

    // R5 restart clears the counter; R6 counter restarts after terminal
    startPlay(8'h00, 1'b0, 5, 1'b1);
    pushBytes(3);
    startPlay(8'h00, 1'b0, 5, 1'b1);
    pushBytes(4);
    chk(irqPend == 1'b0, "R5 count restarted", irqPend, 0);
    pushBytes(1);
    chk(irqPend == 1'b1, "R5 irq after full count", irqPend, 1);
    @(negedge clk);
    intClr = 1'b1;
    @(negedge clk);
    intClr = 1'b0; #1;
    chk(irqPend == 1'b0, "R10 clear", irqPend, 0);
    pushBytes(4);
    chk(irqPend == 1'b0, "R6 second block early", irqPend, 0);
    pushBytes(1);
    chk(irqPend == 1'b1, "R6 second block irq", irqPend, 1);

    // R10 clear colliding with a terminal count: set wins
    @(negedge clk);
    pushBytes(4);
    intClr = 1'b1;
    pushBytes(1);
    intClr = 1'b0;
    chk(irqPend == 1'b1, "R10 set wins over clear", irqPend, 1);

    // R11 invalid rate while running
    @(negedge clk); #1;
    chk(running == 1'b1, "R11 running before", running, 1);
    fmtReg = 8'h08;  // crystal 0, rate index 4
    @(negedge clk); #1;
    chk(rateOk == 1'b0, "R11 rateOk", rateOk, 0);
    chk(running == 1'b0 && byteReady == 1'b0, "R11 stop on bad rate", running, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule